// File: doc/BRIEF.md
# Reset and Clock Start-up Sequencer

This block decides when a small processor system may leave reset and when its core clock may be switched on. It runs from a reference clock that never stops. Three kinds of reset request reach it: power-on, brown-out, and a warm request. The warm request is the OR of the pin, watchdog, software and trap causes. Each kind enters the delay chain at its own point. Every kind then waits out a common internal reset interval, after which the system reset is released.

After release, the block times the start-up of the selected clock source:

- A crystal source must deliver a fixed number of oscillator periods.
- A PLL source waits a lock interval.
- When the fail-safe monitor is on, a settling interval is added. At its end the monitor samples the clock-valid status. If that status is low, the block raises a fall-back flag so the clock mux moves to the internal fast RC clock.

Only then is the clock enable given to the core. All intervals are parameters counted in reference-clock cycles.

Top module: `rst_clk_seq`

## Requirements
- R1: A power-on (asynchronous `arst_n` low, or `por_req`) holds `sys_rst` high for T_POR + T_STUP + T_RST reference cycles.
- R2: A brown-out request holds `sys_rst` high for T_STUP + T_RST cycles.
- R3: A warm request holds `sys_rst` high for T_RST cycles only.
- R4: T_STUP equals T_STUP_REG when `vreg_en` is 1 and T_STUP_NOREG when it is 0.
- R5: With `xtal_sel` = 1, the clock enable follows only after OST_TICKS cycles in which `osc_tick` is high. Cycles with `osc_tick` low do not advance the count.
- R6: With `pll_sel` = 1, a lock interval of T_LOCK cycles follows the crystal count, or follows reset release when there is no crystal. External and RC modes (`xtal_sel` = 0, `pll_sel` = 0) add no clock delay.
- R7: With `fscm_en` = 1, a further T_FSCM cycles are added before the clock enable.
- R8: `clk_en` is never high while `sys_rst` is high. `clk_en` rises only once every required clock interval has ended.
- R9: At the end of the monitor interval, `fsafe` is set when `clk_valid` is 0, and the clock is still released. Any new reset request clears `fsafe`.
- R10: A request in any phase restarts the chain on the next edge, at the entry point of its cause. The priority is power-on over brown-out over warm.
- R11: `phase` reads 0 = power-on delay, 1 = start-up delay, 2 = internal reset, 3 = oscillator count, 4 = PLL lock, 5 = monitor settling, 6 = running. Asynchronous reset gives phase 0, `sys_rst` = 1, `clk_en` = 0 and `fsafe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| por_req | input | 1 | Power-on reset request |
| bor_req | input | 1 | Brown-out reset request |
| warm_req | input | 1 | Pin, watchdog, software or trap reset request |
| xtal_sel | input | 1 | Selected source is a crystal oscillator |
| pll_sel | input | 1 | Selected source goes through the PLL |
| vreg_en | input | 1 | On-chip regulator enabled (short start-up delay) |
| fscm_en | input | 1 | Fail-safe clock monitor enabled |
| osc_tick | input | 1 | One pulse per period of the oscillator being started |
| clk_valid | input | 1 | Status: selected clock is present |
| sys_rst | output | 1 | System reset, active high |
| clk_en | output | 1 | Clock release to the core |
| fsafe | output | 1 | Fall-back to the internal fast RC clock |
| phase | output | 3 | Current sequencer phase |

## Verification
The bench builds the sequencer with every interval cut to a few cycles: T_POR=3, T_STUP_REG=4, T_STUP_NOREG=9, T_RST=5, OST_TICKS=8, T_LOCK=6 and T_FSCM=7. Because the values are distinct, a measured reset length or clock length shows which intervals were summed. This lets each combination of cause, regulator, crystal, PLL and monitor be checked to the exact cycle within a few dozen cycles. The short crystal count also allows a test that stalls the oscillator ticks, followed by a test that restarts the chain in the middle of the count.

// File: rtl/rst_clk_seq.sv
module rst_clk_seq #(
  parameter int T_POR        = 320,
  parameter int T_STUP_REG   = 320,
  parameter int T_STUP_NOREG = 2048000,
  parameter int T_RST        = 640,
  parameter int OST_TICKS    = 1024,
  parameter int T_LOCK       = 640,
  parameter int T_FSCM       = 3200
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       por_req,
  input  logic       bor_req,
  input  logic       warm_req,
  input  logic       xtal_sel,
  input  logic       pll_sel,
  input  logic       vreg_en,
  input  logic       fscm_en,
  input  logic       osc_tick,
  input  logic       clk_valid,
  output logic       sys_rst,
  output logic       clk_en,
  output logic       fsafe,
  output logic [2:0] phase
);
  localparam int M1 = (T_POR > T_STUP_REG) ? T_POR : T_STUP_REG;
  localparam int M2 = (T_STUP_NOREG > T_RST) ? T_STUP_NOREG : T_RST;
  localparam int M3 = (OST_TICKS > T_LOCK) ? OST_TICKS : T_LOCK;
  localparam int M4 = (M1 > M2) ? M1 : M2;
  localparam int M5 = (M3 > T_FSCM) ? M3 : T_FSCM;
  localparam int MAXD = (M4 > M5) ? M4 : M5;
  localparam int CW = $clog2(MAXD + 1);

  typedef enum logic [2:0] {
    PH_PWR = 3'd0, PH_STUP = 3'd1, PH_IRST = 3'd2, PH_OST = 3'd3,
    PH_LOCK = 3'd4, PH_FSCM = 3'd5, PH_RUN = 3'd6
  } ph_t;

  ph_t ph, nxt;
  logic [CW-1:0] cnt;
  logic step;

  wire any_req = por_req | bor_req | warm_req;
  wire [CW-1:0] stup_last = vreg_en ? CW'(T_STUP_REG - 1) : CW'(T_STUP_NOREG - 1);
  wire ph_t after_lock = fscm_en ? PH_FSCM : PH_RUN;
  wire ph_t after_ost  = pll_sel ? PH_LOCK : after_lock;
  wire ph_t after_rst  = xtal_sel ? PH_OST : after_ost;

  always_comb begin
    step = 1'b0;
    nxt  = PH_RUN;
    case (ph)
      PH_PWR:  begin step = (cnt == CW'(T_POR - 1));  nxt = PH_STUP;    end
      PH_STUP: begin step = (cnt == stup_last);       nxt = PH_IRST;    end
      PH_IRST: begin step = (cnt == CW'(T_RST - 1));  nxt = after_rst;  end
      PH_OST:  begin step = osc_tick && (cnt == CW'(OST_TICKS - 1)); nxt = after_ost; end
      PH_LOCK: begin step = (cnt == CW'(T_LOCK - 1)); nxt = after_lock; end
      PH_FSCM: begin step = (cnt == CW'(T_FSCM - 1)); nxt = PH_RUN;     end
      default: begin step = 1'b0;                     nxt = PH_RUN;     end
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ph    <= PH_PWR;
      cnt   <= '0;
      fsafe <= 1'b0;
    end else if (any_req) begin
      ph    <= por_req ? PH_PWR : (bor_req ? PH_STUP : PH_IRST);
      cnt   <= '0;
      fsafe <= 1'b0;
    end else if (step) begin
      ph  <= nxt;
      cnt <= '0;
      if (ph == PH_FSCM) fsafe <= !clk_valid;
    end else if (ph != PH_RUN && (ph != PH_OST || osc_tick)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign sys_rst = (ph == PH_PWR) || (ph == PH_STUP) || (ph == PH_IRST);
  assign clk_en  = (ph == PH_RUN);
  assign phase   = ph;

  assert_ost_hold_R5: assert property (@(posedge clk) disable iff (!arst_n)
    (ph == PH_OST && !osc_tick && !any_req) |=> (ph == PH_OST && $stable(cnt)));

  assert_release_order_R8: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(clk_en) |-> (!$past(any_req) && $past(ph) inside {PH_IRST, PH_OST, PH_LOCK, PH_FSCM}));

  assert_por_restart_R10: assert property (@(posedge clk) disable iff (!arst_n)
    por_req |=> (ph == PH_PWR && sys_rst && !clk_en));

  assert_bor_restart_R10: assert property (@(posedge clk) disable iff (!arst_n)
    (bor_req && !por_req) |=> (ph == PH_STUP && sys_rst));

  assert_fallback_R9: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(fsafe) |-> (clk_en && $past(ph) == PH_FSCM && !$past(clk_valid)));

  assert_phase_legal_R11: assert property (@(posedge clk) disable iff (!arst_n)
    phase != 3'd7);
endmodule

// File: tb/rst_clk_seq_test.sv
module rst_clk_seq_test;
  localparam int TP = 3, TSR = 4, TSN = 9, TR = 5, OST = 8, TL = 6, TF = 7;

  // {cause[1:0] (0 por,1 bor,2 warm), xtal, pll, vreg, fscm, valid, expected fsafe}
  localparam logic [7:0] VEC [8] = '{
    8'b00_00_1_0_1_0, 8'b00_10_0_0_1_0, 8'b01_11_1_1_1_0, 8'b01_01_0_0_1_0,
    8'b10_00_1_1_0_1, 8'b10_10_1_1_1_0, 8'b10_11_0_0_1_0, 8'b00_11_1_1_0_1
  };

  logic clk = 0, arst_n = 0;
  logic por_req = 0, bor_req = 0, warm_req = 0;
  logic xtal_sel = 0, pll_sel = 0, vreg_en = 1, fscm_en = 0, clk_valid = 1, tick_on = 1;
  logic sys_rst, clk_en, fsafe;
  logic [2:0] phase;
  int nchk = 0, nerr = 0, both_high = 0;

  always #5 clk = ~clk;

  rst_clk_seq #(.T_POR(TP), .T_STUP_REG(TSR), .T_STUP_NOREG(TSN), .T_RST(TR),
                .OST_TICKS(OST), .T_LOCK(TL), .T_FSCM(TF)) uut (
    .clk(clk), .arst_n(arst_n), .por_req(por_req), .bor_req(bor_req), .warm_req(warm_req),
    .xtal_sel(xtal_sel), .pll_sel(pll_sel), .vreg_en(vreg_en), .fscm_en(fscm_en),
    .osc_tick(tick_on), .clk_valid(clk_valid), .sys_rst(sys_rst), .clk_en(clk_en),
    .fsafe(fsafe), .phase(phase));

  always @(negedge clk) if (arst_n && clk_en && sys_rst) both_high++;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic req(input logic p, input logic b, input logic w);
    @(negedge clk); por_req = p; bor_req = b; warm_req = w;
    @(negedge clk); por_req = 0; bor_req = 0; warm_req = 0;
  endtask

  task automatic measure(output int r, output int c);
    r = 0; c = 0;
    while (sys_rst && r < 1000) begin r++; @(negedge clk); end
    while (!clk_en && c < 1000) begin c++; @(negedge clk); end
  endtask

  function automatic int rst_len(input int cause, input logic v);
    return (cause == 0 ? TP : 0) + (cause <= 1 ? (v ? TSR : TSN) : 0) + TR;
  endfunction

  function automatic int clk_len(input logic x, input logic p, input logic f);
    return (x ? OST : 0) + (p ? TL : 0) + (f ? TF : 0);
  endfunction

  initial begin
    #(100000 * 10);
    nchk++; nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int r, c;
    repeat (3) @(negedge clk);
    chk("R11 reset sys_rst", sys_rst, 1);
    chk("R11 reset clk_en", clk_en, 0);
    chk("R11 reset fsafe", fsafe, 0);
    chk("R11 reset phase", phase, 0);
    arst_n = 1;
    measure(r, c);
    chk("R1 power-on reset length", r, TP + TSR + TR);
    chk("R6 external mode clock delay", c, 0);

    foreach (VEC[i]) begin
      int cause;
      string tr;
      cause = int'(VEC[i][7:6]);
      xtal_sel = VEC[i][5]; pll_sel = VEC[i][4]; vreg_en = VEC[i][3];
      fscm_en = VEC[i][2]; clk_valid = VEC[i][1];
      tr = (cause == 0) ? "R1" : (cause == 1) ? "R2" : "R3";
      req(cause == 0, cause == 1, cause == 2);
      measure(r, c);
      chk(tr, r, rst_len(cause, VEC[i][3]));
      chk("R6 clock delay sum", c, clk_len(VEC[i][5], VEC[i][4], VEC[i][2]));
      chk("R9 fsafe", fsafe, int'(VEC[i][0]));
      chk("R11 running phase", phase, 6);
    end

    xtal_sel = 0; pll_sel = 0; fscm_en = 0; clk_valid = 1; vreg_en = 0;
    req(0, 1, 0);
    measure(r, c);
    chk("R4 unregulated start-up", r, TSN + TR);

    xtal_sel = 1; pll_sel = 0; fscm_en = 0; tick_on = 0;
    req(0, 0, 1);
    repeat (TR + 20) @(negedge clk);
    chk("R5 stalled count phase", phase, 3);
    chk("R5 stalled count clk_en", clk_en, 0);
    tick_on = 1;
    measure(r, c);
    chk("R5 count after ticks resume", c, OST);

    xtal_sel = 0; fscm_en = 1; clk_valid = 1;
    req(0, 0, 1);
    measure(r, c);
    chk("R7 monitor interval", c, TF);

    xtal_sel = 1; pll_sel = 1; vreg_en = 1;
    req(0, 0, 1);
    repeat (TR + 3) @(negedge clk);
    chk("R10 mid-count phase", phase, 3);
    req(0, 1, 0);
    chk("R10 restart to start-up", phase, 1);
    measure(r, c);
    chk("R10 remaining reset", r, TSR + TR);
    chk("R10 clock after restart", c, OST + TL + TF);

    req(1, 0, 1);
    chk("R10 power-on wins", phase, 0);
    measure(r, c);

    xtal_sel = 0; pll_sel = 0; fscm_en = 1; clk_valid = 0;
    req(0, 0, 1);
    measure(r, c);
    chk("R9 fall-back set", fsafe, 1);
    chk("R9 clock still released", clk_en, 1);
    clk_valid = 1;
    req(0, 0, 1);
    chk("R9 fall-back cleared", fsafe, 0);
    measure(r, c);

    chk("R8 never both high", both_high, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule